// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block decides when a small 8-bit processor core may take a hardware interrupt vector, and which source that vector serves. Each source has a request flag, an enable bit and a level bit (low or high). A global enable gates every source. The core reports three things about the instruction in flight: whether this is its final cycle, whether it is a return-from-interrupt, and whether it writes the enable or level configuration. The arbiter keeps one in-service flag for each of the two levels. When a vector is allowed, it raises a one-cycle call request that carries the winning source index and its level.

Request lines are captured at the close of each instruction's final cycle. The decision made in the final cycle of the next instruction uses that captured copy. A vector is never issued in the middle of an instruction. It is also held back when the instruction ending is a return or a configuration write, so at least one more instruction always runs first. Source flags are cleared by software only. A flag still set when the return executes therefore asks for service again one instruction later.

A combinational wake output reports any enabled pending request to an external power-down controller, with no clock needed. Every pin is a plain control or status signal. The call request is a single-cycle strobe with no ready input, because the core is expected to act on it in the cycle it appears.

Top module: `irq_arbiter`

## Requirements
- R1: While rst_n is low and just after it is released, call_req is 0, in_service is 2'b00 and the captured request copy is all zero.
- R2: The request lines are captured only at the end of a cycle with instr_last=1. A decision uses the copy captured at the previous final cycle, so a request first seen in a final cycle cannot be vectored at that same final cycle.
- R3: A vector is decided only in a cycle with instr_last=1. call_req is registered and goes high for exactly the cycle after the deciding edge; a following cycle without a new decision has call_req=0.
- R4: A source is eligible only when its captured flag, its src_en bit and glob_en are all 1.
- R5: Any eligible high-level source (src_hi bit 1) beats every low-level one. Within a level, the lowest index wins. call_idx gives the index and call_hi gives the level (1 = high).
- R6: No vector is issued when instr_reti or instr_cfg_wr is 1 in the deciding cycle. The request stays pending and is vectored at a later final cycle.
- R7: A low-level winner is blocked while either in_service bit is set. A high-level winner is blocked while in_service[1] is set. In both cases the request stays pending.
- R8: Issuing a vector sets in_service[1] for a high-level winner or in_service[0] for a low-level winner, in the same cycle that call_req rises.
- R9: A final cycle with instr_reti=1 clears in_service[1] if it is set, and otherwise clears in_service[0].
- R10: wake equals glob_en AND the OR over all sources of (req_flags & src_en). It is combinational and needs no clock edge.
- R11: A flag left set through a return is vectored again at the final cycle of the next instruction after the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_flags | input | N_SRC | Raw request flag of each source |
| src_en | input | N_SRC | Per-source enable |
| glob_en | input | 1 | Global interrupt enable |
| src_hi | input | N_SRC | Per-source level, 1 = high |
| instr_last | input | 1 | Current cycle is the final cycle of the instruction |
| instr_reti | input | 1 | Current instruction is a return-from-interrupt |
| instr_cfg_wr | input | 1 | Current instruction writes enable or level configuration |
| call_req | output | 1 | One-cycle hardware call request |
| call_idx | output | $clog2(N_SRC) | Index of the vectored source |
| call_hi | output | 1 | Level of the vectored source |
| in_service | output | 2 | In-service flags, bit 1 high, bit 0 low |
| wake | output | 1 | Any enabled request pending (combinational) |

## Verification
A table of request, enable, level and global-enable patterns covers these cases: a single source, ties inside one level, a high source against a lower-index low source, masking by src_en, masking by glob_en, and all-masked inputs. Together they separate the level rule from the index order and from the enable gating. Directed sequences cover several further cases. A request is held across non-final cycles to show it is neither captured nor vectored there. Decisions fall on return and configuration-write cycles to show they are withheld and later granted. Nested low-then-high service shows preemption, blocking and highest-first release. Finally, a flag kept set through a return shows the one-instruction gap before the second vector.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_CNT = 2;
  localparam int LVL_LO  = 0;
  localparam int LVL_HI  = 1;
endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int WIDTH = 8,
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] vec,
  output logic             any,
  output logic [IW-1:0]    idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else if (cap_en) held <= raw;
  end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track
  import irq_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               grant,
  input  logic               grant_hi,
  input  logic               ret_done,
  output logic [LVL_CNT-1:0] active
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
    end else if (grant) begin
      active[grant_hi ? LVL_HI : LVL_LO] <= 1'b1;
    end else if (ret_done) begin
      if (active[LVL_HI]) active[LVL_HI] <= 1'b0;
      else                active[LVL_LO] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   req_flags,
  input  logic [N_SRC-1:0]   src_en,
  input  logic               glob_en,
  input  logic [N_SRC-1:0]   src_hi,
  input  logic               instr_last,
  input  logic               instr_reti,
  input  logic               instr_cfg_wr,
  output logic               call_req,
  output logic [IW-1:0]      call_idx,
  output logic               call_hi,
  output logic [LVL_CNT-1:0] in_service,
  output logic               wake
);
  logic [N_SRC-1:0] held;
  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] lvl_vec [LVL_CNT];
  logic [LVL_CNT-1:0] lvl_any;
  logic [IW-1:0]    lvl_idx [LVL_CNT];
  logic             win_any, win_hi, blocked, take;
  logic [IW-1:0]    win_idx;

  irq_req_capture #(.WIDTH(N_SRC)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(instr_last), .raw(req_flags), .held(held)
  );

  assign elig = held & src_en & {N_SRC{glob_en}};

  for (genvar l = 0; l < LVL_CNT; l++) begin : g_lvl
    assign lvl_vec[l] = (l == LVL_HI) ? (elig & src_hi) : (elig & ~src_hi);
    irq_lowest_pick #(.WIDTH(N_SRC)) u_pick (
      .vec(lvl_vec[l]), .any(lvl_any[l]), .idx(lvl_idx[l])
    );
  end

  assign win_hi  = lvl_any[LVL_HI];
  assign win_any = |lvl_any;
  assign win_idx = win_hi ? lvl_idx[LVL_HI] : lvl_idx[LVL_LO];
  assign blocked = win_hi ? in_service[LVL_HI] : (|in_service);
  assign take    = instr_last & ~instr_reti & ~instr_cfg_wr & win_any & ~blocked;

  irq_level_track u_track (
    .clk(clk), .rst_n(rst_n), .grant(take), .grant_hi(win_hi),
    .ret_done(instr_last & instr_reti), .active(in_service)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      call_req <= 1'b0;
      call_idx <= '0;
      call_hi  <= 1'b0;
    end else begin
      call_req <= take;
      if (take) begin
        call_idx <= win_idx;
        call_hi  <= win_hi;
      end
    end
  end

  assign wake = glob_en & (|(req_flags & src_en));
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int N_SRC = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       instr_last,
  input logic       instr_reti,
  input logic       instr_cfg_wr,
  input logic       call_req,
  input logic       call_hi,
  input logic [1:0] in_service
);
  // R3
  only_final_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(instr_last));
  // R6
  no_vector_after_ret_or_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (!$past(instr_reti) && !$past(instr_cfg_wr)));
  // R7
  low_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !call_hi) |-> ($past(in_service) == 2'b00));
  // R7
  high_needs_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && call_hi) |-> !$past(in_service[1]));
  // R8
  level_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (call_hi ? in_service[1] : in_service[0]));
  // R9
  ret_clears_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(instr_last && instr_reti) && $past(in_service[1])) |-> !in_service[1]);
endmodule

bind irq_arbiter irq_arbiter_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_last(instr_last), .instr_reti(instr_reti),
  .instr_cfg_wr(instr_cfg_wr), .call_req(call_req), .call_hi(call_hi),
  .in_service(in_service)
);

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_flags = '0, src_en = '0, src_hi = '0;
  logic glob_en = 1'b0, instr_last = 1'b0, instr_reti = 1'b0, instr_cfg_wr = 1'b0;
  logic call_req, call_hi, wake;
  logic [2:0] call_idx;
  logic [1:0] in_service;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_arbiter #(.N_SRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_flags(req_flags), .src_en(src_en), .glob_en(glob_en),
    .src_hi(src_hi), .instr_last(instr_last), .instr_reti(instr_reti),
    .instr_cfg_wr(instr_cfg_wr), .call_req(call_req), .call_idx(call_idx),
    .call_hi(call_hi), .in_service(in_service), .wake(wake)
  );

  // flags, en, hi, glob, exp_valid, exp_idx, exp_hi
  localparam logic [29:0] TBL [8] = '{
    {8'h01, 8'hFF, 8'h00, 1'b1, 1'b1, 3'd0, 1'b0},
    {8'h0C, 8'hFF, 8'h00, 1'b1, 1'b1, 3'd2, 1'b0},
    {8'h81, 8'hFF, 8'h80, 1'b1, 1'b1, 3'd7, 1'b1},
    {8'h30, 8'h20, 8'h00, 1'b1, 1'b1, 3'd5, 1'b0},
    {8'hFF, 8'hFF, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0},
    {8'h50, 8'hFF, 8'h50, 1'b1, 1'b1, 3'd4, 1'b1},
    {8'h02, 8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 1'b0},
    {8'hA0, 8'hFF, 8'h20, 1'b1, 1'b1, 3'd5, 1'b1}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic last, input logic reti, input logic cfg);
    instr_last = last; instr_reti = reti; instr_cfg_wr = cfg;
    @(posedge clk); #1;
  endtask

  task automatic flush();
    req_flags = '0;
    cyc(1, 1, 0); cyc(1, 1, 0); cyc(1, 0, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(call_req, 0, "R1 call_req in reset");
    chk(in_service, 0, "R1 in_service in reset");
    rst_n = 1'b1;
    cyc(0, 0, 0);
    chk(call_req, 0, "R1 call_req after release");
    src_en = 8'hFF; glob_en = 1'b1; req_flags = 8'h10;
    cyc(1, 0, 0);
    chk(call_req, 0, "R1 captured copy is zero after reset");
    flush();

    // Table walk: R4 R5
    for (int t = 0; t < 8; t++) begin
      req_flags = TBL[t][29:22]; src_en = TBL[t][21:14];
      src_hi = TBL[t][13:6]; glob_en = TBL[t][5];
      cyc(1, 0, 0);
      chk(call_req, 0, "R2 no vector at capturing final cycle");
      cyc(1, 0, 0);
      chk(call_req, TBL[t][4], "R4 R5 vector valid");
      if (TBL[t][4]) begin
        chk(call_idx, TBL[t][3:1], "R5 winner index");
        chk(call_hi, TBL[t][0], "R5 winner level");
        chk(in_service, TBL[t][0] ? 2'b10 : 2'b01, "R8 level marked");
      end
      req_flags = '0;
      cyc(1, 1, 0);
      chk(in_service, 0, "R9 return clears level");
      cyc(1, 0, 0);
    end
    src_en = 8'hFF; src_hi = '0; glob_en = 1'b1;

    // R2 R3: no capture or decision in non-final cycles
    req_flags = 8'h08;
    cyc(0, 0, 0); cyc(0, 0, 0);
    chk(call_req, 0, "R3 no vector mid-instruction");
    cyc(1, 0, 0);
    chk(call_req, 0, "R2 not captured in non-final cycles");
    cyc(0, 0, 0);
    chk(call_req, 0, "R3 no vector mid-instruction with capture held");
    cyc(1, 0, 0);
    chk(call_req, 1, "R2 vector at next final cycle");
    chk(call_idx, 3, "R2 vector index");
    cyc(0, 0, 0);
    chk(call_req, 0, "R3 call_req lasts one cycle");
    flush();

    // R6 config write and return suppress
    req_flags = 8'h40;
    cyc(1, 0, 0);
    cyc(1, 0, 1);
    chk(call_req, 0, "R6 suppressed by config write");
    cyc(1, 1, 0);
    chk(call_req, 0, "R6 suppressed by return");
    cyc(1, 0, 0);
    chk(call_req, 1, "R6 pending request granted later");
    chk(call_idx, 6, "R6 index");
    flush();

    // R7 R9 nesting
    req_flags = 8'h01;
    cyc(1, 0, 0); cyc(1, 0, 0);
    chk(in_service, 2'b01, "R8 low in service");
    req_flags = 8'h03; src_hi = 8'h02;
    cyc(1, 0, 0);
    chk(call_req, 0, "R7 low blocked by low in service");
    cyc(1, 0, 0);
    chk(call_req, 1, "R7 high preempts low");
    chk(call_idx, 1, "R7 preempt index");
    chk(call_hi, 1, "R7 preempt level");
    chk(in_service, 2'b11, "R8 both levels in service");
    cyc(1, 0, 0);
    chk(call_req, 0, "R7 high blocked by high in service");
    cyc(1, 1, 0);
    chk(in_service, 2'b01, "R9 return clears high first");
    chk(call_req, 0, "R6 no vector on return");
    cyc(1, 1, 0);
    chk(in_service, 2'b00, "R9 second return clears low");
    cyc(1, 0, 0);
    chk(call_req, 1, "R11 uncleared high re-vectored");
    chk(call_idx, 1, "R11 index");
    src_hi = '0;
    flush();

    // R11 low flag kept through return
    req_flags = 8'h04;
    cyc(1, 0, 0); cyc(1, 0, 0);
    chk(call_req, 1, "R11 first vector");
    cyc(1, 1, 0);
    chk(call_req, 0, "R11 no vector at return");
    chk(in_service, 0, "R9 cleared by return");
    cyc(1, 0, 0);
    chk(call_req, 1, "R11 vector after one instruction");
    chk(call_idx, 2, "R11 index");
    flush();

    // R10 wake combinational
    @(negedge clk);
    req_flags = 8'h20; src_en = 8'h20; glob_en = 1'b1; #1;
    chk(wake, 1, "R10 wake with enabled request");
    glob_en = 1'b0; #1;
    chk(wake, 0, "R10 wake gated by global enable");
    glob_en = 1'b1; src_en = 8'hDF; #1;
    chk(wake, 0, "R10 wake gated by source enable");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule